// File: doc/BRIEF.md
# Duty-Cycled Omnipolar Threshold Switch

This block is the digital decision and power-sequencing core of a low-power magnetic proximity switch. A free-running timer divides time into repeating periods. Each period opens with a short awake window and then sleeps for the rest. While the window is open, the block raises an enable to an external sensing front end. At the close of the window it captures one signed field-strength sample and decides whether the switch is on. The decision is then held through the whole sleep interval.

The switch responds to either field polarity. Each pole has its own operate and release thresholds, and the gap between them gives that pole its hysteresis. The four thresholds are held in registers that load while a configuration-valid signal is high, and they come out of reset at typical values. A static strap selects whether the output is driven at the normal or the inverted level. A one-cycle strobe marks every decision instant.

Top module: `omni_mag_switch`

## Requirements
- R1: After reset, `fe_en_o` is high for the first `AWAKE_CYC` cycles of every `PERIOD_CYC`-cycle period and low for the rest. The first window starts in the first cycle after reset is released.
- R2: `sample_o` is high for exactly one cycle per period. That cycle is the first cycle in which `fe_en_o` is low again, and the switch state reflects the new decision in that same cycle.
- R3: The switch state changes only in a cycle where `sample_o` is high. Field changes during sleep have no effect on `switch_o`.
- R4: The decision uses only the value of `field_i` in the last awake cycle. Values presented earlier in the window are ignored.
- R5: From off, a field strictly greater than the south operate threshold turns the switch on.
- R6: From off, a field strictly less than the north operate threshold turns the switch on.
- R7: From on, the switch turns off only when the field is strictly below the south release threshold and strictly above the north release threshold. A field equal to either release threshold keeps it on.
- R8: A field exactly equal to an operate threshold does not turn the switch on.
- R9: With `invert_i`=0, `switch_o` is 1 when on and 0 when off. With `invert_i`=1 the levels are swapped.
- R10: Reset leaves the switch off (`switch_o` = `invert_i`) with `sample_o` low. The thresholds reset to south operate +37, south release +31, north operate -40 and north release -34, so a zero field keeps the switch off.
- R11: The thresholds load from the `cfg_*_i` buses at a clock edge where `cfg_valid_i` is high. Values on those buses while `cfg_valid_i` is low have no effect.
- R12: All fields and thresholds are 12-bit two's complement and are compared with signed ordering, so -2048 is below every threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| cfg_valid_i | input | 1 | load all four thresholds at this edge |
| cfg_s_op_i | input | FIELD_W | south operate threshold (signed) |
| cfg_s_rp_i | input | FIELD_W | south release threshold (signed) |
| cfg_n_op_i | input | FIELD_W | north operate threshold (signed) |
| cfg_n_rp_i | input | FIELD_W | north release threshold (signed) |
| invert_i | input | 1 | static output polarity strap |
| field_i | input | FIELD_W | signed field sample from the front end |
| fe_en_o | output | 1 | front-end enable, high during the awake window |
| sample_o | output | 1 | one-cycle pulse at each decision instant |
| switch_o | output | 1 | latched switch output, polarity per invert_i |

## Verification
The hardest case to reach is a window in which the field is above an operate point for most of the awake time but drops below it in the last awake cycle only. This shows that the decision ignores the settling part of the window. To build it, the stimulus waits for the rising edge of `fe_en_o`, then counts awake cycles in the bench and changes `field_i` on the falling clock edge just before the capture edge. The mirror case is also covered. Release behaviour is driven in order through the exact release values, then one step past them, so that the hysteresis edges are each reached from the on state.

// File: rtl/oms_pkg.sv
package oms_pkg;
  typedef enum logic {
    SW_OFF = 1'b0,
    SW_ON  = 1'b1
  } sw_state_e;

  typedef enum logic {
    POLE_SOUTH = 1'b0,
    POLE_NORTH = 1'b1
  } pole_e;
endpackage

// File: rtl/oms_duty_timer.sv
module oms_duty_timer #(
  parameter int AWAKE_CYC  = 45,
  parameter int PERIOD_CYC = 45000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic awake_o,
  output logic last_awake_o
);
  localparam int CNT_W = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [CNT_W-1:0] WRAP = CNT_W'(PERIOD_CYC - 1);
  localparam logic [CNT_W-1:0] AWK  = CNT_W'(AWAKE_CYC);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(AWAKE_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (cnt_q == WRAP) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign awake_o      = (cnt_q < AWK);
  assign last_awake_o = (cnt_q == LAST);
endmodule

// File: rtl/oms_thresh_regs.sv
module oms_thresh_regs #(
  parameter int FIELD_W  = 12,
  parameter int S_OP_DEF = 37,
  parameter int S_RP_DEF = 31,
  parameter int N_OP_DEF = -40,
  parameter int N_RP_DEF = -34
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      load_i,
  input  logic        [FIELD_W-1:0] s_op_i,
  input  logic        [FIELD_W-1:0] s_rp_i,
  input  logic        [FIELD_W-1:0] n_op_i,
  input  logic        [FIELD_W-1:0] n_rp_i,
  output logic signed [FIELD_W-1:0] s_op_o,
  output logic signed [FIELD_W-1:0] s_rp_o,
  output logic signed [FIELD_W-1:0] n_op_o,
  output logic signed [FIELD_W-1:0] n_rp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s_op_o <= FIELD_W'(S_OP_DEF);
      s_rp_o <= FIELD_W'(S_RP_DEF);
      n_op_o <= FIELD_W'(N_OP_DEF);
      n_rp_o <= FIELD_W'(N_RP_DEF);
    end else if (load_i) begin
      s_op_o <= s_op_i;
      s_rp_o <= s_rp_i;
      n_op_o <= n_op_i;
      n_rp_o <= n_rp_i;
    end
  end
endmodule

// File: rtl/oms_pole_cmp.sv
module oms_pole_cmp
  import oms_pkg::*;
#(
  parameter int    FIELD_W = 12,
  parameter pole_e POLE    = POLE_SOUTH
) (
  input  logic signed [FIELD_W-1:0] field_i,
  input  logic signed [FIELD_W-1:0] op_i,
  input  logic signed [FIELD_W-1:0] rp_i,
  output logic                      operate_o,
  output logic                      released_o
);
  // south pole works on the positive side, north pole is its mirror
  generate
    if (POLE == POLE_SOUTH) begin : g_south
      assign operate_o  = (field_i > op_i);
      assign released_o = (field_i < rp_i);
    end else begin : g_north
      assign operate_o  = (field_i < op_i);
      assign released_o = (field_i > rp_i);
    end
  endgenerate
endmodule

// File: rtl/oms_decide.sv
module oms_decide
  import oms_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic capture_i,
  input  logic s_operate_i,
  input  logic n_operate_i,
  input  logic s_released_i,
  input  logic n_released_i,
  output logic on_o,
  output logic strobe_o
);
  sw_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SW_OFF: if (s_operate_i || n_operate_i)    state_d = SW_ON;
      SW_ON:  if (s_released_i && n_released_i)  state_d = SW_OFF;
      default: state_d = SW_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= SW_OFF;
      strobe_o <= 1'b0;
    end else begin
      strobe_o <= capture_i;
      if (capture_i) state_q <= state_d;
    end
  end

  assign on_o = (state_q == SW_ON);
endmodule

// File: rtl/omni_mag_switch.sv
module omni_mag_switch
  import oms_pkg::*;
#(
  parameter int FIELD_W    = 12,
  parameter int AWAKE_CYC  = 45,
  parameter int PERIOD_CYC = 45000,
  parameter int S_OP_DEF   = 37,
  parameter int S_RP_DEF   = 31,
  parameter int N_OP_DEF   = -40,
  parameter int N_RP_DEF   = -34
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_valid_i,
  input  logic [FIELD_W-1:0] cfg_s_op_i,
  input  logic [FIELD_W-1:0] cfg_s_rp_i,
  input  logic [FIELD_W-1:0] cfg_n_op_i,
  input  logic [FIELD_W-1:0] cfg_n_rp_i,
  input  logic               invert_i,
  input  logic [FIELD_W-1:0] field_i,
  output logic               fe_en_o,
  output logic               sample_o,
  output logic               switch_o
);
  localparam int NPOLE = 2;

  logic                      last_awake;
  logic                      on;
  logic signed [FIELD_W-1:0] field_s;
  logic signed [FIELD_W-1:0] op_thr  [NPOLE];
  logic signed [FIELD_W-1:0] rp_thr  [NPOLE];
  logic        [NPOLE-1:0]   operate;
  logic        [NPOLE-1:0]   released;

  assign field_s = field_i;

  oms_duty_timer #(
    .AWAKE_CYC (AWAKE_CYC),
    .PERIOD_CYC(PERIOD_CYC)
  ) u_timer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .awake_o     (fe_en_o),
    .last_awake_o(last_awake)
  );

  oms_thresh_regs #(
    .FIELD_W (FIELD_W),
    .S_OP_DEF(S_OP_DEF),
    .S_RP_DEF(S_RP_DEF),
    .N_OP_DEF(N_OP_DEF),
    .N_RP_DEF(N_RP_DEF)
  ) u_thr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(cfg_valid_i),
    .s_op_i(cfg_s_op_i),
    .s_rp_i(cfg_s_rp_i),
    .n_op_i(cfg_n_op_i),
    .n_rp_i(cfg_n_rp_i),
    .s_op_o(op_thr[0]),
    .s_rp_o(rp_thr[0]),
    .n_op_o(op_thr[1]),
    .n_rp_o(rp_thr[1])
  );

  for (genvar p = 0; p < NPOLE; p++) begin : g_pole
    oms_pole_cmp #(
      .FIELD_W(FIELD_W),
      .POLE   ((p == 0) ? POLE_SOUTH : POLE_NORTH)
    ) u_cmp (
      .field_i   (field_s),
      .op_i      (op_thr[p]),
      .rp_i      (rp_thr[p]),
      .operate_o (operate[p]),
      .released_o(released[p])
    );
  end

  oms_decide u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .capture_i   (last_awake),
    .s_operate_i (operate[0]),
    .n_operate_i (operate[1]),
    .s_released_i(released[0]),
    .n_released_i(released[1]),
    .on_o        (on),
    .strobe_o    (sample_o)
  );

  assign switch_o = on ^ invert_i;
endmodule

// File: rtl/oms_chk.sv
module oms_chk #(
  parameter int AWAKE_CYC = 45
) (
  input logic clk_i,
  input logic rst_ni,
  input logic invert_i,
  input logic fe_en_o,
  input logic sample_o,
  input logic switch_o
);
  localparam int RUN_W = $clog2(AWAKE_CYC + 2);
  logic [RUN_W-1:0] awake_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      awake_run_q <= '0;
    else if (fe_en_o) awake_run_q <= awake_run_q + 1'b1;
    else              awake_run_q <= '0;
  end

  // R1
  awake_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fe_en_o |-> (awake_run_q < RUN_W'(AWAKE_CYC)));

  // R2
  strobe_at_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(fe_en_o) |-> sample_o);

  // R2
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);

  // R2
  strobe_asleep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> !fe_en_o);

  // R3
  hold_between_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sample_o && $stable(invert_i)) |-> $stable(switch_o));
endmodule

bind omni_mag_switch oms_chk #(.AWAKE_CYC(AWAKE_CYC)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .invert_i(invert_i),
  .fe_en_o (fe_en_o),
  .sample_o(sample_o),
  .switch_o(switch_o)
);

// File: tb/omni_mag_switch_tb_top.sv
module omni_mag_switch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int W          = 12;
  localparam int AWAKE      = 4;
  localparam int PERIOD     = 16;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                cfg_valid = 1'b0;
  logic signed [W-1:0] s_op = 12'sd37, s_rp = 12'sd31, n_op = -12'sd40, n_rp = -12'sd34;
  logic                invert = 1'b0;
  logic signed [W-1:0] field = '0;
  logic                fe_en, sample, sw;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  omni_mag_switch #(
    .FIELD_W(W), .AWAKE_CYC(AWAKE), .PERIOD_CYC(PERIOD)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cfg_valid_i(cfg_valid),
    .cfg_s_op_i(s_op), .cfg_s_rp_i(s_rp), .cfg_n_op_i(n_op), .cfg_n_rp_i(n_rp),
    .invert_i(invert), .field_i(field),
    .fe_en_o(fe_en), .sample_o(sample), .switch_o(sw)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // wait for a fresh window start, seen at a falling edge
  task automatic to_window_start();
    while (fe_en) @(negedge clk);
    while (!fe_en) @(negedge clk);
  endtask

  // one window: early value during settling, late value in last awake cycle
  task automatic window(input string req, input logic signed [W-1:0] early,
                        input logic signed [W-1:0] late, input logic exp_sw);
    to_window_start();
    field = early;
    repeat (AWAKE - 1) @(negedge clk);
    chk({req, " awake before capture"}, int'(fe_en), 1);
    field = late;
    @(negedge clk);
    chk({req, " strobe R2"}, int'(sample), 1);
    chk({req, " enable low R1"}, int'(fe_en), 0);
    chk({req, " switch"}, int'(sw), int'(exp_sw));
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 switch off in reset", int'(sw), 0);
    chk("R10 strobe low in reset", int'(sample), 0);
    rst_n = 1'b1;
    for (int i = 0; i < AWAKE; i++) begin
      chk("R1 awake after reset", int'(fe_en), 1);
      chk("R2 no early strobe", int'(sample), 0);
      @(negedge clk);
    end
    chk("R2 first strobe", int'(sample), 1);
    chk("R10 zero field off", int'(sw), 0);
    @(negedge clk);
    chk("R2 strobe one cycle", int'(sample), 0);
    for (int i = 0; i < PERIOD - AWAKE - 1; i++) begin
      chk("R1 asleep", int'(fe_en), 0);
      @(negedge clk);
    end
    chk("R1 next window", int'(fe_en), 1);
  endtask

  task automatic t_south();
    window("R8 south equal", 37, 37, 1'b0);
    window("R5 south above", 38, 38, 1'b1);
    window("R7 at south release", 31, 31, 1'b1);
    window("R7 between", 32, 32, 1'b1);
    window("R7 south release", 30, 30, 1'b0);
  endtask

  task automatic t_north();
    window("R8 north equal", -40, -40, 1'b0);
    window("R6 north below", -41, -41, 1'b1);
    window("R7 at north release", -34, -34, 1'b1);
    window("R7 north release", -33, -33, 1'b0);
  endtask

  task automatic t_last_cycle();
    window("R4 early high ignored", 100, 0, 1'b0);
    window("R4 late high used", 0, 100, 1'b1);
    window("R4 early low ignored", 0, 0, 1'b0);
  endtask

  task automatic t_sleep_hold();
    window("R3 set on", 200, 200, 1'b1);
    @(negedge clk);
    field = 0;
    while (!fe_en) begin
      chk("R3 hold during sleep", int'(sw), 1);
      @(negedge clk);
    end
    window("R3 release", 0, 0, 1'b0);
    @(negedge clk);
    field = 500;
    while (!fe_en) begin
      chk("R3 off hold during sleep", int'(sw), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_invert();
    window("R9 prep off", 0, 0, 1'b0);
    invert = 1'b1;
    @(negedge clk);
    chk("R9 inverted off", int'(sw), 1);
    window("R9 inverted on", 50, 50, 1'b0);
    invert = 1'b0;
    @(negedge clk);
    chk("R9 normal on", int'(sw), 1);
    window("R9 normal off", 0, 0, 1'b0);
  endtask

  task automatic t_cfg();
    s_op = 100; s_rp = 90; n_op = -100; n_rp = -90;
    cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
    s_op = 10; s_rp = 5; n_op = -10; n_rp = -5;
    window("R11 new operate not crossed", 80, 80, 1'b0);
    window("R11 unloaded values ignored", -50, -50, 1'b0);
    window("R11 new operate crossed", 101, 101, 1'b1);
    window("R11 new release not crossed", 95, 95, 1'b1);
    window("R11 new release crossed", 89, 89, 1'b0);
    s_op = 37; s_rp = 31; n_op = -40; n_rp = -34;
    cfg_valid = 1'b1;
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic t_signed();
    window("R12 most negative", -2048, -2048, 1'b1);
    window("R12 back to zero", 0, 0, 1'b0);
    window("R12 most positive", 2047, 2047, 1'b1);
    window("R12 small negative releases", -1, -1, 1'b0);
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected 0", cyc);
      finish_run();
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_south();
    t_north();
    t_last_cycle();
    t_sleep_hold();
    t_invert();
    t_cfg();
    t_signed();
    finish_run();
  end
endmodule